// File: doc/BRIEF.md
# Look-Up-Table Duty Compensator

This block closes the digital loop between a low-resolution error A/D and a pulse-width modulator. Once per switching period the A/D presents a signed error sample; the block produces the next duty command as the present duty plus three signed contributions. Each contribution comes from its own small programmable table. The current error indexes the first table, the error one period old indexes the second, and the error two periods old indexes the third. No multiplier is needed because the error can take only a handful of values, so every coefficient product is stored ahead of time.

The tables are filled through a plain write port while the loop is halted. The run enable then starts the loop, and each accepted sample moves the two-stage error history and updates the duty register. The sum is clamped to the duty range instead of wrapping.

Top module: `lut_duty_comp`

## Requirements
- R1: After reset `dutyOut` is 0, `dutyValid` is 0, both stored past errors are 0 and every table entry is 0. A step taken before any table is written therefore leaves the duty at 0.
- R2: When `sampleValid` and `runEn` are both high at a rising edge, `dutyOut` after that edge equals the saturated value of (previous duty + first[e(n)] + second[e(n-1)] + third[e(n-2)]), and `dutyValid` is high for exactly that one following cycle.
- R3: The error history shifts only on an accepted step. The current sample becomes the one-period-old error, and the old one-period value becomes the two-period-old error.
- R4: A sum above 255 produces `dutyOut` = 255.
- R5: A sum below 0 produces `dutyOut` = 0.
- R6: A `sampleValid` pulse while `runEn` is low changes neither the duty nor the error history, and it does not raise `dutyValid`.
- R7: With `runEn` low, a `tblWrEn` pulse stores `tblData` (a 10-bit two's-complement value) at `tblAddr` in the table chosen by `tblSel`: 0 selects the current-error table, 1 the one-period-old table, 2 the two-period-old table.
- R8: A table write attempted while `runEn` is high is ignored.
- R9: A table write with `tblSel` = 3 changes no table.
- R10: Tables are indexed by the raw 4-bit two's-complement error code. For example, error -4 uses index 12 and error +3 uses index 3. Both `sampleErr` and `tblAddr` use this encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | High: loop runs. Low: tables may be written |
| sampleValid | input | 1 | One-cycle strobe marking a new A/D error sample |
| sampleErr | input | 4 | Error sample, two's complement |
| tblWrEn | input | 1 | Table write strobe |
| tblSel | input | 2 | Table select for a write |
| tblAddr | input | 4 | Entry index (error code) for a write |
| tblData | input | 10 | Signed contribution to store |
| dutyOut | output | 8 | Registered duty command |
| dutyValid | output | 1 | High for one cycle after each duty update |

## Verification
The bench builds the block with its default widths: a 4-bit error, 10-bit table entries and an 8-bit duty. It fills all sixteen entries of all three tables with distinct linear patterns. With these patterns, an error routed to the wrong table, a history that shifts at the wrong time, or a sign-extension mistake gives a duty that differs from the bench's own model. The entry width allows contributions from -512 to +511, so a single step can push the sum well beyond either clamp. This brings both saturation edges within reach in a few steps.

// File: rtl/lutcomp_pkg.sv
package lutcomp_pkg;

  // Number of look-up tables, fixed by the three-term control law.
  localparam int NUM_TABLES = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  step;   // accept sample and update duty
    logic [NUM_TABLES-1:0] wrSel;  // one-hot table write enable
  } ctrlStrobes_t;

endpackage

// File: rtl/lutcomp_ctrl.sv
module lutcomp_ctrl
  import lutcomp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  input  logic         sampleValid,
  input  logic         tblWrEn,
  input  logic [1:0]   tblSel,
  output ctrlStrobes_t strobes,
  output logic         dutyValid
);

  // Samples are taken only in run mode; writes only when halted.
  always_comb begin
    strobes.step  = runEn & sampleValid;
    strobes.wrSel = '0;
    if (tblWrEn && !runEn) begin
      case (tblSel)
        2'd0:    strobes.wrSel = 3'b001;
        2'd1:    strobes.wrSel = 3'b010;
        2'd2:    strobes.wrSel = 3'b100;
        default: strobes.wrSel = 3'b000;  // unused select: dropped (R9)
      endcase
    end
  end

  // Update marker lines up with the duty register in the datapath.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dutyValid <= 1'b0;
    else       dutyValid <= strobes.step;
  end

endmodule

// File: rtl/lutcomp_dp.sv
module lutcomp_dp
  import lutcomp_pkg::*;
#(
  parameter int ERR_W  = 4,
  parameter int COEF_W = 10,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ERR_W-1:0]  sampleErr,
  input  logic [ERR_W-1:0]  tblAddr,
  input  logic [COEF_W-1:0] tblData,
  output logic [DUTY_W-1:0] dutyOut
);

  localparam int DEPTH  = 1 << ERR_W;
  localparam int WIDE_W = (DUTY_W + 1 > COEF_W) ? DUTY_W + 1 : COEF_W;
  localparam int SUM_W  = WIDE_W + 3;
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'((1 << DUTY_W) - 1);

  // Error history: one and two periods old (R3).
  logic [ERR_W-1:0] errD1, errD2;

  // Per-table read index and read data.
  logic [ERR_W-1:0]  idx  [NUM_TABLES];
  logic [COEF_W-1:0] term [NUM_TABLES];

  assign idx[0] = sampleErr;
  assign idx[1] = errD1;
  assign idx[2] = errD2;

  genvar t;
  generate
    for (t = 0; t < NUM_TABLES; t++) begin : gTbl
      logic [COEF_W-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (strobes.wrSel[t]) begin
          mem[tblAddr] <= tblData;
        end
      end

      assign term[t] = mem[idx[t]];
    end
  endgenerate

  // Sign-extended sum of previous duty and the three contributions.
  logic [SUM_W-1:0] sumNext;
  logic [DUTY_W-1:0] dutyNext;

  always_comb begin
    sumNext = {{(SUM_W-DUTY_W){1'b0}}, dutyOut};
    for (int k = 0; k < NUM_TABLES; k++) begin
      sumNext = sumNext + {{(SUM_W-COEF_W){term[k][COEF_W-1]}}, term[k]};
    end
    if (sumNext[SUM_W-1])        dutyNext = '0;                // R5
    else if (sumNext > SUM_MAX)  dutyNext = {DUTY_W{1'b1}};    // R4
    else                         dutyNext = DUTY_W'(sumNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errD1   <= '0;
      errD2   <= '0;
      dutyOut <= '0;
    end else if (strobes.step) begin
      errD1   <= sampleErr;
      errD2   <= errD1;
      dutyOut <= dutyNext;
    end
  end

  // Duty is frozen between accepted samples (R6)
  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> $stable(dutyOut));

  // History is frozen between accepted samples (R3)
  p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> ($stable(errD1) && $stable(errD2)));

  // The oldest error is the previous one-period error after a step (R3)
  p_hist_chain_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (errD2 == $past(errD1)));

endmodule

// File: rtl/lut_duty_comp.sv
module lut_duty_comp
  import lutcomp_pkg::*;
#(
  parameter int ERR_W  = 4,
  parameter int COEF_W = 10,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              sampleValid,
  input  logic [ERR_W-1:0]  sampleErr,
  input  logic              tblWrEn,
  input  logic [1:0]        tblSel,
  input  logic [ERR_W-1:0]  tblAddr,
  input  logic [COEF_W-1:0] tblData,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyValid
);

  ctrlStrobes_t strobes;

  lutcomp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .sampleValid (sampleValid),
    .tblWrEn     (tblWrEn),
    .tblSel      (tblSel),
    .strobes     (strobes),
    .dutyValid   (dutyValid)
  );

  lutcomp_dp #(
    .ERR_W  (ERR_W),
    .COEF_W (COEF_W),
    .DUTY_W (DUTY_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleErr (sampleErr),
    .tblAddr   (tblAddr),
    .tblData   (tblData),
    .dutyOut   (dutyOut)
  );

  // Update marker only follows an accepted sample (R2)
  p_valid_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    dutyValid |-> $past(sampleValid && runEn));

  // No table is written while the loop runs (R8)
  p_no_write_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> (strobes.wrSel == '0));

  // At most one table is written per cycle (R7)
  p_one_table_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrSel));

endmodule

// File: tb/sim_lut_duty_comp.sv
module sim_lut_duty_comp;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       sampleValid = 1'b0;
  logic [3:0] sampleErr = '0;
  logic       tblWrEn = 1'b0;
  logic [1:0] tblSel = '0;
  logic [3:0] tblAddr = '0;
  logic [9:0] tblData = '0;
  logic [7:0] dutyOut;
  logic       dutyValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lut_duty_comp u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .sampleValid(sampleValid),
    .sampleErr(sampleErr), .tblWrEn(tblWrEn), .tblSel(tblSel),
    .tblAddr(tblAddr), .tblData(tblData), .dutyOut(dutyOut),
    .dutyValid(dutyValid)
  );

  // Bench model of the requirements
  int mTbl [3][16];
  int mDuty = 0;
  int mD1 = 0;
  int mD2 = 0;

  localparam int NVEC = 12;
  localparam int VEC_ERR [NVEC] = '{3, -2, 1, 0, 4, -4, 2, 2, -1, 0, -3, 1};

  function automatic int ix(input int e);
    return e & 15;  // R10: raw two's-complement code
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doStep(input int e, input string tag);
    int s;
    @(negedge clk);
    runEn = 1'b1; sampleValid = 1'b1; sampleErr = 4'(e);
    @(negedge clk);
    sampleValid = 1'b0;
    s = mDuty + mTbl[0][ix(e)] + mTbl[1][ix(mD1)] + mTbl[2][ix(mD2)];
    mDuty = (s < 0) ? 0 : (s > 255) ? 255 : s;
    mD2 = mD1; mD1 = e;
    check({tag, " duty"}, int'(dutyOut), mDuty);
    check({tag, " valid"}, int'(dutyValid), 1);
  endtask

  task automatic doWrite(input int sel, input int e, input int val, input bit run);
    @(negedge clk);
    runEn = run; tblWrEn = 1'b1; tblSel = 2'(sel);
    tblAddr = 4'(e); tblData = 10'(val);
    @(negedge clk);
    tblWrEn = 1'b0; runEn = 1'b0;
    if (!run && sel < 3) mTbl[sel][ix(e)] = val;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 16; b++) mTbl[a][b] = 0;

    repeat (3) @(negedge clk);
    check("R1 reset duty", int'(dutyOut), 0);
    check("R1 reset valid", int'(dutyValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 duty after release", int'(dutyOut), 0);

    // R1: zero tables give zero duty
    doStep(3, "R1 empty tables");
    doStep(0, "R1 empty tables");
    doStep(0, "R1 empty tables");
    @(negedge clk);
    check("R2 valid one cycle", int'(dutyValid), 0);

    // R7/R10: fill all tables with distinct patterns
    for (int e = -8; e < 8; e++) begin
      doWrite(0, e, 12 * e + 3, 1'b0);
      doWrite(1, e, -5 * e, 1'b0);
      doWrite(2, e, 2 * e - 1, 1'b0);
    end

    // R2/R3/R7/R10: vector walk
    for (int v = 0; v < NVEC; v++) doStep(VEC_ERR[v], "R2 R3 R7 R10 vector");

    // R6: sample ignored while halted
    @(negedge clk);
    runEn = 1'b0; sampleValid = 1'b1; sampleErr = 4'(4);
    @(negedge clk);
    sampleValid = 1'b0;
    check("R6 duty held", int'(dutyOut), mDuty);
    check("R6 no valid", int'(dutyValid), 0);
    doStep(-1, "R6 history held");
    doStep(2, "R6 history held");

    // R8: write while running ignored
    doWrite(0, 0, 200, 1'b1);
    doStep(0, "R8 run write ignored");

    // R9: unused select writes nothing
    doWrite(3, 1, 300, 1'b0);
    doStep(1, "R9 sel3 ignored");
    doStep(1, "R9 sel3 ignored");
    doStep(1, "R9 sel3 ignored");

    // R4: clamp high
    doWrite(0, 4, 511, 1'b0);
    for (int k = 0; k < 4; k++) doStep(4, "R4 clamp high");
    check("R4 at max", int'(dutyOut), 255);

    // R5: clamp low
    doWrite(0, -4, -512, 1'b0);
    for (int k = 0; k < 4; k++) doStep(-4, "R5 clamp low");
    check("R5 at min", int'(dutyOut), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule